// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received frame should be kept, judging only its 48-bit destination address. The address is compared against a bank of exact-match station slots, looked up in a 4096-bit multicast hash table, and tested against a broadcast rule. Two promiscuous switches, one for unicast and one for multicast, can widen acceptance.

Configuration arrives over a simple word-write port. That port loads the hash table words, the low and high words of each station slot, and a mode word. The receive path presents a destination address with a one-cycle strobe. Exactly one cycle later the block returns a verdict, together with a flag that marks acceptances made by the imprecise hash rather than by an exact slot.

Address byte 0 is the first byte on the wire and sits in `da[7:0]`. Byte 5 sits in `da[47:40]`.

Top module: `dafilt_top`

## Requirements
- R1: After a synchronous reset, `res_valid` is 0, every slot is invalid, every hash table bit is 0 and all three mode bits are 0, so any address (broadcast included) is rejected.
- R2: Station slot i has its low word at write address 128+2i and its high word at 129+2i. The low word holds address bytes 3..0 with byte 0 in bits 7:0. The high word holds byte 5 in bits 15:8 and byte 4 in bits 7:0. An address equal to a valid slot is accepted with `res_inexact` 0.
- R3: A slot whose high-word bit 31 (its valid flag) is 0 never matches. Setting that bit makes the same slot match.
- R4: Hash table word w sits at write address w (0..127). For an address with `da[0]`=1 (multicast), the table bit selected by word `da[47:41]` and bit `da[40:36]` accepts the address. `res_inexact` is 1 when this bit is set and no valid slot matches.
- R5: The hash table is ignored for addresses with `da[0]`=0 (unicast). Such an address is never accepted by the table, and `res_inexact` is then 0.
- R6: Mode word bit 0 (write address 160) enables unicast promiscuous mode: every unicast address is accepted. This mode does not accept multicast addresses.
- R7: Mode word bit 1 enables multicast promiscuous mode: every multicast address is accepted. This mode does not accept unicast addresses, and `res_inexact` still follows R4.
- R8: Mode word bit 2 enables broadcast acceptance: the all-ones address is accepted.
- R9: A strobe on `da_valid` in cycle N gives `res_valid` high in cycle N+1 only, with the verdict for the address presented in cycle N. Lookups may run back to back. `res_accept` and `res_inexact` are 0 whenever `res_valid` is 0.
- R10: A write replaces the whole addressed word. It affects lookups from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 9 | Configuration word address (table, slots, mode) |
| wr_data | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_inexact | output | 1 | Acceptance came from the hash table |

## Verification
Each wrong internal state shows up at the ports on the verdict that follows the next lookup touching it:
- A slot that kept a stale valid flag, or that compares a misplaced byte, turns an expected accept into a reject, or the reverse.
- A hash index taken from the wrong address bits flips both `res_accept` and `res_inexact` for multicast addresses that share a table word.
- A mode bit wired to the wrong rule changes the verdict for the opposite address class.

The scoreboard pairs every strobe with its verdict one cycle later, so a dropped or extra `res_valid` pulse is reported at once.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam int DA_W = 48;

    typedef struct packed {
        logic bcast_ok;
        logic mc_promisc;
        logic uc_promisc;
    } mode_t;

    typedef struct packed {
        logic accept;
        logic inexact;
    } verdict_t;

    function automatic logic is_group(input logic [DA_W-1:0] a);
        return a[0];
    endfunction

    function automatic logic is_all_ones(input logic [DA_W-1:0] a);
        return &a;
    endfunction

endpackage

// File: rtl/dafilt_slot_bank.sv
module dafilt_slot_bank #(
    parameter int NUM_SLOTS = 16,
    parameter int ADDR_W    = 9,
    parameter int BASE      = 128
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    input  logic [dafilt_pkg::DA_W-1:0] da,
    output logic                       exact_hit
);
    logic [NUM_SLOTS-1:0] hits;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam int LO_ADDR = BASE + 2 * i;
        localparam int HI_ADDR = BASE + 2 * i + 1;
        logic [31:0] lo_q;
        logic [15:0] hi_q;
        logic        vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q  <= '0;
                hi_q  <= '0;
                vld_q <= 1'b0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(LO_ADDR)) lo_q <= wr_data;
                if (wr_addr == ADDR_W'(HI_ADDR)) begin
                    hi_q  <= wr_data[15:0];
                    vld_q <= wr_data[31];
                end
            end
        end

        assign hits[i] = vld_q && (da[31:0] == lo_q) && (da[47:32] == hi_q);
    end

    assign exact_hit = |hits;
endmodule

// File: rtl/dafilt_hash_table.sv
module dafilt_hash_table #(
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [$clog2(WORDS*WORD_W)-1:0] idx,
    output logic                     hash_hit
);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int WSEL_W = $clog2(WORDS);

    logic [WORD_W-1:0] tbl [WORDS];
    logic [WSEL_W-1:0] wsel;
    logic [BIT_W-1:0]  bsel;

    assign wsel = idx[BIT_W +: WSEL_W];
    assign bsel = idx[BIT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) tbl[w] <= '0;
        end else if (wr_en && (wr_addr < ADDR_W'(WORDS))) begin
            tbl[wr_addr[WSEL_W-1:0]] <= wr_data;
        end
    end

    assign hash_hit = tbl[wsel][bsel];
endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
    import dafilt_pkg::*;
(
    input  logic [DA_W-1:0] da,
    input  mode_t           mode,
    input  logic            exact_hit,
    input  logic            hash_hit,
    output verdict_t        verdict
);
    logic grp, bcast, tbl_ok;

    always_comb begin
        grp    = is_group(da);
        bcast  = is_all_ones(da);
        tbl_ok = grp && hash_hit;
        verdict.accept  = exact_hit
                        || (bcast && mode.bcast_ok)
                        || (!grp && mode.uc_promisc)
                        || (grp && mode.mc_promisc)
                        || tbl_ok;
        verdict.inexact = tbl_ok && !exact_hit;
    end
endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
    import dafilt_pkg::*;
#(
    parameter int NUM_SLOTS  = 16,
    parameter int HASH_WORDS = 128,
    parameter int WORD_W     = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [8:0]      wr_addr,
    input  logic [31:0]     wr_data,
    input  logic            da_valid,
    input  logic [47:0]     da,
    output logic            res_valid,
    output logic            res_accept,
    output logic            res_inexact
);
    localparam int SLOT_BASE = HASH_WORDS;
    localparam int MODE_ADDR = HASH_WORDS + 2 * NUM_SLOTS;
    localparam int ADDR_W    = 9;
    localparam int HIDX_W    = $clog2(HASH_WORDS * WORD_W);

    mode_t    mode_q;
    logic     exact_hit, hash_hit;
    verdict_t verdict;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(MODE_ADDR)) mode_q <= mode_t'(wr_data[2:0]);
    end

    dafilt_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .BASE(SLOT_BASE)) u_slots (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .da(da), .exact_hit(exact_hit)
    );

    dafilt_hash_table #(.WORDS(HASH_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_hash (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .idx(da[DA_W-1 -: HIDX_W]), .hash_hit(hash_hit)
    );

    dafilt_decide u_decide (
        .da(da), .mode(mode_q), .exact_hit(exact_hit), .hash_hit(hash_hit), .verdict(verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_accept  <= 1'b0;
            res_inexact <= 1'b0;
        end else begin
            res_valid   <= da_valid;
            res_accept  <= da_valid && verdict.accept;
            res_inexact <= da_valid && verdict.inexact;
        end
    end

    AST_VERDICT_FOLLOWS: assert property (@(posedge clk) disable iff (rst) da_valid |=> res_valid); // R9
    AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (rst) !da_valid |=> !res_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !res_valid |-> !res_accept && !res_inexact); // R9
    AST_INEXACT_ACCEPTS: assert property (@(posedge clk) disable iff (rst) res_inexact |-> res_accept); // R4
    AST_UCAST_NO_TABLE: assert property (@(posedge clk) disable iff (rst) da_valid && !da[0] |=> !res_inexact); // R5
    AST_UC_PROMISC: assert property (@(posedge clk) disable iff (rst) da_valid && !da[0] && mode_q.uc_promisc |=> res_accept); // R6
    AST_MC_PROMISC: assert property (@(posedge clk) disable iff (rst) da_valid && da[0] && mode_q.mc_promisc |=> res_accept); // R7
    AST_BCAST_OK: assert property (@(posedge clk) disable iff (rst) da_valid && (&da) && mode_q.bcast_ok |=> res_accept); // R8
endmodule

// File: tb/dafilt_top_bench.sv
`timescale 1ns/1ps
module dafilt_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        res_valid, res_accept, res_inexact;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    q_acc[$];
    bit    q_inx[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    dafilt_top u_dafilt_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .da_valid(da_valid), .da(da), .res_valid(res_valid),
        .res_accept(res_accept), .res_inexact(res_inexact)
    );

    task automatic write_word(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drives one strobe at a falling edge and leaves it there; the next call or idle() replaces it.
    task automatic lookup(input logic [47:0] a, input bit acc, input bit inx, input string tag);
        @(negedge clk);
        da_valid = 1'b1; da = a;
        q_acc.push_back(acc); q_inx.push_back(inx); q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            da_valid = 1'b0;
        end
    endtask

    // Monitor: pops one expected verdict per res_valid pulse
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            checks++;
            if (q_acc.size() == 0) begin
                fails++;
                $display("FAIL R9: verdict with no lookup pending (actual valid=1, expected 0)");
            end else begin
                bit e_acc, e_inx;
                string t;
                e_acc = q_acc.pop_front(); e_inx = q_inx.pop_front(); t = q_tag.pop_front();
                if (res_accept !== e_acc || res_inexact !== e_inx) begin
                    fails++;
                    $display("FAIL %s: accept/inexact actual %b/%b expected %b/%b",
                             t, res_accept, res_inexact, e_acc, e_inx);
                end
            end
        end
    end

    task automatic check_idle(input string tag);
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || q_acc.size() != 0) begin
            fails++;
            $display("FAIL %s: valid=%b pending=%0d expected valid=0 pending=0",
                     tag, res_valid, q_acc.size());
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung (actual running, expected finished)");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R1");
        // R1: cleared state rejects everything
        lookup(48'h665544332210, 0, 0, "R1");
        lookup(48'hFFFFFFFFFFFF, 0, 0, "R1");
        lookup(48'h5A7300000001, 0, 0, "R1");
        idle(2);

        // R2: slot 3 exact match
        write_word(134, 32'h44332210);
        write_word(135, 32'h80006655);
        lookup(48'h665544332210, 1, 0, "R2");
        lookup(48'h665544332212, 0, 0, "R2");
        idle(2);

        // R3: slot 5 without valid flag, then with
        write_word(138, 32'hCCDDEE00);
        write_word(139, 32'h0000AABB);
        lookup(48'hAABBCCDDEE00, 0, 0, "R3");
        idle(1);
        write_word(139, 32'h8000AABB);
        lookup(48'hAABBCCDDEE00, 1, 0, "R3");
        idle(2);

        // R4: word 45 bit 7 covers byte5=0x5A byte4=0x7x
        write_word(45, 32'h00000080);
        lookup(48'h5A7300000001, 1, 1, "R4");
        lookup(48'h5A6300000001, 0, 0, "R4");
        lookup(48'h5B7300000001, 0, 0, "R4");
        idle(2);
        // R5: same hash bits, unicast
        lookup(48'h5A7300000000, 0, 0, "R5");
        idle(1);
        // R4: exact slot 7 overrides the inexact flag
        write_word(142, 32'h00000001);
        write_word(143, 32'h80005A73);
        lookup(48'h5A7300000001, 1, 0, "R4");
        lookup(48'h5A7F00000011, 1, 1, "R4");
        idle(2);

        // R8: broadcast accept
        lookup(48'hFFFFFFFFFFFF, 0, 0, "R8");
        idle(1);
        write_word(160, 32'h4);
        lookup(48'hFFFFFFFFFFFF, 1, 0, "R8");
        lookup(48'h123456789ABC, 0, 0, "R8");
        idle(2);

        // R6: unicast promiscuous
        write_word(160, 32'h1);
        lookup(48'h123456789ABC, 1, 0, "R6");
        lookup(48'h123456789ABD, 0, 0, "R6");
        lookup(48'hFFFFFFFFFFFF, 0, 0, "R6");
        idle(2);

        // R7: multicast promiscuous
        write_word(160, 32'h2);
        lookup(48'h123456789ABD, 1, 0, "R7");
        lookup(48'h123456789ABC, 0, 0, "R7");
        lookup(48'h5A7300000003, 1, 1, "R7");
        idle(2);
        check_idle("R9");

        // R10: overwrite of a table word replaces it
        write_word(160, 32'h0);
        write_word(45, 32'h00000040);
        lookup(48'h5A7300000003, 0, 0, "R10");
        lookup(48'h5A6300000003, 1, 1, "R10");
        idle(2);

        // R1: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        lookup(48'h665544332210, 0, 0, "R1");
        lookup(48'h5A6300000001, 0, 0, "R1");
        idle(3);
        check_idle("R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule